// File: doc/BRIEF.md
# ATM Cell Header Filter

This block sits after header error checking in an ATM receive path. For every cell it is given the 32-bit header word and a one-cycle valid strobe. It sorts the cell into one of four kinds: user, idle, unassigned or invalid. It also compares the header with a programmable masked pattern. From these results it decides whether the cell is kept or dropped, and it reports that decision one clock later.

Three saturating counters run alongside the decision path. The first counts pattern hits, where the pattern mode defines what a hit is. The second counts unassigned cells that were filtered. The third counts every discarded cell. A synchronous clear input zeroes all three counters.

The header fields are laid out as follows:

| Field | Bits |
|---|---|
| GFC | 31:28 |
| VPI | 27:20 |
| VCI | 19:4 |
| PT | 3:1 |
| CLP | 0 |

Top module: `atm_hdr_filter`

## Requirements
- R1: `dec_vld` goes high in the cycle after a cycle with `cell_vld` high. `dec_pass` and `dec_type` hold that cell's result from then until the next cell. After reset, `dec_vld` is 0 and all counters are 0.
- R2: `dec_type` is coded as follows. It is 1 (idle) when the header equals 32'h0000_0001. It is 2 (unassigned) when bits 27:4 and bit 0 are all zero, whatever GFC and PT are. It is 3 (invalid) when bits 27:4 are zero and the cell is neither idle nor unassigned. Otherwise it is 0 (user). User cells are never dropped by the type filters.
- R3: A cell matches when `((cell_hdr ^ pat_value) & pat_mask) == 0`. In `pat_mode` 0 a match is a hit. In `pat_mode` 1 a mismatch is a hit. Each hit adds one to `pat_cnt`, and neither mode drops a cell.
- R4: In `pat_mode` 2 a match is a hit. In `pat_mode` 3 a mismatch is a hit. In both modes a hit is counted in `pat_cnt` and the cell is dropped.
- R5: Idle cells are dropped while `idle_pass` is 0 and passed while it is 1.
- R6: Unassigned cells pass while `unasgn_drop` is 0. While it is 1 they are dropped and counted in `unasgn_cnt`.
- R7: Invalid cells pass while `inval_drop` is 0 and are dropped while it is 1.
- R8: A cell is dropped if any enabled filter selects it; otherwise it passes. `drop_cnt` counts each dropped cell once, even when several filters select it.
- R9: Each counter stops at 2^CNT_W-1 and does not wrap.
- R10: `cnt_clr` makes all counters read 0 in the next cycle. It wins over an increment in the same cycle.
- R11: While `cell_vld` is low, the counters do not change unless cleared, and `dec_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_vld | input | 1 | Header word valid this cycle |
| cell_hdr | input | 32 | Cell header word |
| idle_pass | input | 1 | 1 passes idle cells |
| unasgn_drop | input | 1 | 1 drops and counts unassigned cells |
| inval_drop | input | 1 | 1 drops invalid cells |
| pat_mode | input | 2 | Pattern mode 0..3 |
| pat_value | input | 32 | Header pattern |
| pat_mask | input | 32 | Compare mask, 1 = compared |
| cnt_clr | input | 1 | Synchronous counter clear |
| dec_vld | output | 1 | Decision valid |
| dec_pass | output | 1 | 1 = keep, 0 = discard |
| dec_type | output | 2 | Cell type code |
| pat_cnt | output | CNT_W | Pattern hit count |
| unasgn_cnt | output | CNT_W | Filtered unassigned count |
| drop_cnt | output | CNT_W | Discarded cell count |

## Verification
A counter clear and a counted cell can arrive in the same cycle. The bench provokes this by raising `cnt_clr` together with a cell that the pattern filter drops. It then checks that every counter reads zero while the decision for that cell is still reported as a drop.

A single cell can also be selected by the unassigned filter and the pattern filter at once. The bench judges that case by checking that `drop_cnt` goes up by exactly one.

// File: rtl/atm_hdr_filter_pkg.sv
package atm_hdr_filter_pkg;

    localparam int HDR_W    = 32;
    localparam int VPI_LSB  = 20;
    localparam int VCI_LSB  = 4;
    localparam int VPVC_W   = 24;
    localparam logic [HDR_W-1:0] IDLE_WORD = 32'h0000_0001;

    typedef enum logic [1:0] {
        CT_USER    = 2'd0,
        CT_IDLE    = 2'd1,
        CT_UNASGN  = 2'd2,
        CT_INVALID = 2'd3
    } cell_type_e;

    typedef enum logic [1:0] {
        PM_CNT_HIT   = 2'd0,
        PM_CNT_MISS  = 2'd1,
        PM_DROP_HIT  = 2'd2,
        PM_DROP_MISS = 2'd3
    } pat_mode_e;

    typedef struct packed {
        logic       vld;
        logic       pass;
        cell_type_e ctype;
    } dec_t;

endpackage

// File: rtl/hdr_classifier.sv
module hdr_classifier
    import atm_hdr_filter_pkg::*;
(
    input  logic [HDR_W-1:0] hdr,
    output cell_type_e       ctype
);
    logic vpvc_zero;
    logic clp;

    always_comb begin
        vpvc_zero = (hdr[VCI_LSB +: VPVC_W] == '0);
        clp       = hdr[0];
        if (hdr == IDLE_WORD)
            ctype = CT_IDLE;
        else if (vpvc_zero && !clp)
            ctype = CT_UNASGN;
        else if (vpvc_zero)
            ctype = CT_INVALID;
        else
            ctype = CT_USER;
    end
endmodule

// File: rtl/hdr_pattern_match.sv
module hdr_pattern_match
    import atm_hdr_filter_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] hdr,
    input  logic [W-1:0] pat,
    input  logic [W-1:0] mask,
    input  pat_mode_e    mode,
    output logic         hit,
    output logic         drop_sel
);
    logic match;

    always_comb begin
        match = (((hdr ^ pat) & mask) == '0);
        unique case (mode)
            PM_CNT_HIT, PM_DROP_HIT:   hit = match;
            PM_CNT_MISS, PM_DROP_MISS: hit = !match;
            default:                   hit = 1'b0;
        endcase
        drop_sel = hit && (mode == PM_DROP_HIT || mode == PM_DROP_MISS);
    end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && cnt_q != MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAX && !clr) |=> (cnt_q == MAX)); // R9
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> (cnt_q >= $past(cnt_q))); // R9
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/atm_hdr_filter.sv
module atm_hdr_filter
    import atm_hdr_filter_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_vld,
    input  logic [31:0]      cell_hdr,
    input  logic             idle_pass,
    input  logic             unasgn_drop,
    input  logic             inval_drop,
    input  logic [1:0]       pat_mode,
    input  logic [31:0]      pat_value,
    input  logic [31:0]      pat_mask,
    input  logic             cnt_clr,
    output logic             dec_vld,
    output logic             dec_pass,
    output logic [1:0]       dec_type,
    output logic [CNT_W-1:0] pat_cnt,
    output logic [CNT_W-1:0] unasgn_cnt,
    output logic [CNT_W-1:0] drop_cnt
);
    localparam int NUM_CNT = 3;
    localparam int IX_PAT  = 0;
    localparam int IX_UNA  = 1;
    localparam int IX_DROP = 2;

    cell_type_e ctype;
    logic       pat_hit, pat_drop;
    logic       type_drop, drop;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];
    dec_t st_d, st_q;

    hdr_classifier u_class (
        .hdr   (cell_hdr),
        .ctype (ctype)
    );

    hdr_pattern_match #(.W(HDR_W)) u_match (
        .hdr      (cell_hdr),
        .pat      (pat_value),
        .mask     (pat_mask),
        .mode     (pat_mode_e'(pat_mode)),
        .hit      (pat_hit),
        .drop_sel (pat_drop)
    );

    always_comb begin
        unique case (ctype)
            CT_IDLE:    type_drop = !idle_pass;
            CT_UNASGN:  type_drop = unasgn_drop;
            CT_INVALID: type_drop = inval_drop;
            default:    type_drop = 1'b0;
        endcase
        drop = type_drop || pat_drop;

        cnt_inc          = '0;
        cnt_inc[IX_PAT]  = cell_vld && pat_hit;
        cnt_inc[IX_UNA]  = cell_vld && ctype == CT_UNASGN && unasgn_drop;
        cnt_inc[IX_DROP] = cell_vld && drop;

        st_d     = st_q;
        st_d.vld = cell_vld;
        if (cell_vld) begin
            st_d.pass  = !drop;
            st_d.ctype = ctype;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (cnt_inc[i]),
            .cnt   (cnt_val[i])
        );
    end

    assign dec_vld    = st_q.vld;
    assign dec_pass   = st_q.pass;
    assign dec_type   = st_q.ctype;
    assign pat_cnt    = cnt_val[IX_PAT];
    assign unasgn_cnt = cnt_val[IX_UNA];
    assign drop_cnt   = cnt_val[IX_DROP];

    AST_DEC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cell_vld |=> dec_vld); // R1
    AST_NO_SPURIOUS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_vld |=> !dec_vld); // R11
    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_vld && cell_hdr == IDLE_WORD && !idle_pass && !cnt_clr)
        |=> (!dec_pass && drop_cnt != '0)); // R5
    AST_PAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cell_vld && !cnt_clr) |=> $stable(pat_cnt)); // R11
    AST_DROP_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && !dec_pass && !$past(cnt_clr)) |-> (drop_cnt != '0)); // R8
endmodule

// File: tb/atm_hdr_filter_tb.sv
module atm_hdr_filter_tb;
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cell_vld = 1'b0;
    logic [31:0] cell_hdr = '0;
    logic idle_pass = 1'b0, unasgn_drop = 1'b0, inval_drop = 1'b0;
    logic [1:0] pat_mode = '0;
    logic [31:0] pat_value = '0, pat_mask = '0;
    logic cnt_clr = 1'b0;
    logic dec_vld, dec_pass;
    logic [1:0] dec_type;
    logic [CNT_W-1:0] pat_cnt, unasgn_cnt, drop_cnt;

    int tests = 0, fails = 0;
    int exp_pat = 0, exp_una = 0, exp_drop = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    atm_hdr_filter #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cell_vld(cell_vld), .cell_hdr(cell_hdr),
        .idle_pass(idle_pass), .unasgn_drop(unasgn_drop), .inval_drop(inval_drop),
        .pat_mode(pat_mode), .pat_value(pat_value), .pat_mask(pat_mask),
        .cnt_clr(cnt_clr), .dec_vld(dec_vld), .dec_pass(dec_pass),
        .dec_type(dec_type), .pat_cnt(pat_cnt), .unasgn_cnt(unasgn_cnt),
        .drop_cnt(drop_cnt)
    );

    typedef struct packed {
        logic [31:0] hdr;
        logic        ip;
        logic        ud;
        logic        id;
        logic [1:0]  mode;
        logic [31:0] pat;
        logic [31:0] mask;
        logic        pass;
        logic [1:0]  ctype;
        logic        hit;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{32'h0123_4560, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b1, 2'd0, 1'b1}, // R3 hit
        '{32'h0000_0001, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 2'd1, 1'b0}, // R5
        '{32'h0000_0001, 1'b1, 1'b0, 1'b0, 2'd1, 32'h0, 32'h0, 1'b1, 2'd1, 1'b0}, // R5
        '{32'h0000_0000, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0, 32'h0, 1'b1, 2'd2, 1'b0}, // R6
        '{32'h0000_000E, 1'b0, 1'b1, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 2'd2, 1'b0}, // R6
        '{32'h0000_0003, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0, 32'h0, 1'b1, 2'd3, 1'b0}, // R7
        '{32'h0000_0003, 1'b0, 1'b0, 1'b1, 2'd1, 32'h0, 32'h0, 1'b0, 2'd3, 1'b0}, // R7
        '{32'h1234_5670, 1'b0, 1'b0, 1'b0, 2'd2, 32'h1230_0000, 32'hFFF0_0000, 1'b0, 2'd0, 1'b1}, // R4
        '{32'h4560_0000, 1'b0, 1'b0, 1'b0, 2'd2, 32'h1230_0000, 32'hFFF0_0000, 1'b1, 2'd0, 1'b0}, // R4
        '{32'h4560_0000, 1'b0, 1'b0, 1'b0, 2'd3, 32'h1230_0000, 32'hFFF0_0000, 1'b0, 2'd0, 1'b1}, // R4
        '{32'h1234_5670, 1'b0, 1'b0, 1'b0, 2'd3, 32'h1230_0000, 32'hFFF0_0000, 1'b1, 2'd0, 1'b0}, // R4
        '{32'h4560_0000, 1'b0, 1'b0, 1'b0, 2'd1, 32'h1230_0000, 32'hFFF0_0000, 1'b1, 2'd0, 1'b1}, // R3
        '{32'h1234_5670, 1'b0, 1'b0, 1'b0, 2'd0, 32'h1230_0000, 32'hFFF0_0000, 1'b1, 2'd0, 1'b1}, // R3
        '{32'h0000_0000, 1'b0, 1'b1, 1'b0, 2'd2, 32'h0, 32'hFFFF_FFFF, 1'b0, 2'd2, 1'b1}, // R8
        '{32'h0A00_00F0, 1'b0, 1'b1, 1'b1, 2'd1, 32'h0, 32'h0, 1'b1, 2'd0, 1'b0}, // R2
        '{32'h1000_0000, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0, 32'h0, 1'b1, 2'd2, 1'b0}  // R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > int'(CMAX)) ? int'(CMAX) : v;
    endfunction

    task automatic send(input vec_t v, input logic clr);
        @(negedge clk);
        cell_hdr = v.hdr; idle_pass = v.ip; unasgn_drop = v.ud; inval_drop = v.id;
        pat_mode = v.mode; pat_value = v.pat; pat_mask = v.mask;
        cell_vld = 1'b1; cnt_clr = clr;
        @(negedge clk);
        cell_vld = 1'b0; cnt_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset dec_vld", 32'(dec_vld), 32'd0);
        check("R1 reset pat_cnt", 32'(pat_cnt), 32'd0);
        check("R1 reset drop_cnt", 32'(drop_cnt), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            send(VECS[i], 1'b0);
            exp_pat  = sat(exp_pat + int'(VECS[i].hit));
            exp_una  = sat(exp_una + int'(VECS[i].ctype == 2'd2 && VECS[i].ud));
            exp_drop = sat(exp_drop + int'(!VECS[i].pass));
            check($sformatf("R1 vec%0d dec_vld", i), 32'(dec_vld), 32'd1);
            check($sformatf("R8 vec%0d pass", i), 32'(dec_pass), 32'(VECS[i].pass));
            check($sformatf("R2 vec%0d type", i), 32'(dec_type), 32'(VECS[i].ctype));
            check($sformatf("R3 vec%0d pat_cnt", i), 32'(pat_cnt), 32'(exp_pat));
            check($sformatf("R6 vec%0d unasgn_cnt", i), 32'(unasgn_cnt), 32'(exp_una));
            check($sformatf("R8 vec%0d drop_cnt", i), 32'(drop_cnt), 32'(exp_drop));
        end

        // R11: idle cycles leave counters and decision alone
        repeat (4) @(negedge clk);
        check("R11 dec_vld low", 32'(dec_vld), 32'd0);
        check("R11 pat_cnt held", 32'(pat_cnt), 32'(exp_pat));
        check("R11 drop_cnt held", 32'(drop_cnt), 32'(exp_drop));
        check("R1 dec_pass held", 32'(dec_pass), 32'(VECS[NV-1].pass));

        // R9: saturation with mode 2, mask 0 (every cell hits and drops)
        for (int i = 0; i < 20; i++)
            send('{32'h5555_5550, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0, 32'h0, 1'b0, 2'd0, 1'b1}, 1'b0);
        check("R9 pat_cnt saturates", 32'(pat_cnt), 32'(CMAX));
        check("R9 drop_cnt saturates", 32'(drop_cnt), 32'(CMAX));
        check("R9 unasgn_cnt unchanged", 32'(unasgn_cnt), 32'(exp_una));

        // R10: clear in the same cycle as a counted, dropped cell
        send('{32'h5555_5550, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0, 32'h0, 1'b0, 2'd0, 1'b1}, 1'b1);
        check("R10 pat_cnt cleared", 32'(pat_cnt), 32'd0);
        check("R10 drop_cnt cleared", 32'(drop_cnt), 32'd0);
        check("R10 unasgn_cnt cleared", 32'(unasgn_cnt), 32'd0);
        check("R10 decision still drop", 32'(dec_pass), 32'd0);

        // R6: counting resumes after clear
        send('{32'h0000_0000, 1'b0, 1'b1, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 2'd2, 1'b0}, 1'b0);
        check("R6 unasgn_cnt after clear", 32'(unasgn_cnt), 32'd1);
        check("R8 drop_cnt after clear", 32'(drop_cnt), 32'd1);
        check("R3 pat_cnt no hit", 32'(pat_cnt), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule